// File: doc/BRIEF.md
# At-Speed Launch/Capture Scan Sequencer

This block drives one chain of multiplexed scan flip-flops through a complete transition-fault test. A tester loads the first vector serially, the block launches a transition, captures the response one functional cycle later, and then unloads that response on a serial output. Each flip-flop in the chain updates only on cycles where `chain_ce` is high. `scan_en` picks between the serial path and the functional path.

Two launch styles are offered.
- **Shift-launch:** the second vector is one extra shift of the first. `scan_en` drops straight after that shift, so the capture comes exactly one cycle later.
- **Functional launch:** the first vector is fully loaded and `scan_en` is then released. Two back-to-back functional pulses follow. The first loads the circuit's response as the second vector, and the second pulse captures.

`scan_en` travels to the chain through `SE_STAGES` register stages. The sequencer therefore decides every chain-side event `SE_STAGES` cycles ahead and sends its clock enable and serial data through a matched delay. As a result, `scan_en` arrives at the flip-flops in step with the enable it qualifies.

The tester-side serial interface uses strobes without back-pressure.
- `si_take` high means `scan_in` is consumed at the coming clock edge, so the tester must present the next bit during that cycle.
- `so_valid` high means `scan_out` carries a response bit during that cycle.

A second start during loading or launch queues one further pattern of the same length. Its load then overlaps the unload of the current response.

Top module: `atspeed_launch_ctrl`

## Requirements
- R1: When `start` is high in idle, the block latches `mode` (0 = shift-launch, 1 = functional launch) and `len_m1`, which is the chain length minus one, so 0..255 gives lengths 1..256. `busy` is high from the next cycle until the pattern completes.
- R2: After a synchronous reset (`rst_n` low at a clock edge), `busy`, `done`, `scan_en`, `chain_ce`, `si_take` and `so_valid` are all low, including when the reset interrupts a running pattern.
- R3: Loading takes exactly L cycles with `si_take` high. L is the chain length. `si_take` is never high while `busy` is low.
- R4: In shift-launch mode, L+1 tester bits are consumed. The last one is the launch shift, performed with `scan_en` high. The chain's next enabled cycle follows immediately and has `scan_en` low.
- R5: In functional-launch mode, exactly L tester bits are consumed. The launch pulse and the capture pulse fall on consecutive cycles, both with `chain_ce` high and `scan_en` low.
- R6: Unloading produces exactly L `so_valid` bits while `scan_en` is high. The first of these is the last flip-flop of the chain.
- R7: For a chain around a combinational function f, the unloaded word is f(shift(v1,b)) in shift-launch mode and f(f(v1)) in functional-launch mode. Here v1 is the loaded vector and b is the extra launch bit.
- R8: A single pattern keeps `busy` high for 2L+3+SE_STAGES cycles, and `done` pulses for one cycle in the last of them.
- R9: A start during loading, launch or capture queues one pattern of the same length in the newly given mode. The queued pattern's L load bits are taken while the first response is unloaded, and `busy` stays high for 3L+5+SE_STAGES cycles in total.
- R10: A start arriving while unloading with nothing queued, or in the final drain cycles, is ignored. `busy` timing and the number of bits taken are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse from the tester |
| mode | input | 1 | Launch style: 0 shift-launch, 1 functional launch |
| len_m1 | input | LEN_W | Chain length minus one |
| scan_in | input | 1 | Serial vector bit from the tester |
| si_take | output | 1 | `scan_in` is consumed at the next edge |
| scan_out | output | 1 | Serial response bit to the tester |
| so_valid | output | 1 | `scan_out` holds a response bit |
| chain_si | output | 1 | Serial input of the chain's first flip-flop |
| chain_so | input | 1 | Serial output of the chain's last flip-flop |
| chain_ce | output | 1 | Clock enable to every chain flip-flop |
| scan_en | output | 1 | Pipelined scan-enable at the flip-flops |
| busy | output | 1 | A pattern is in progress |
| done | output | 1 | One-cycle pulse when a pattern completes |

## Verification
The bench puts a six-flop chain around a small non-linear function. It sweeps every load vector in functional-launch mode, and every load vector with both launch bits in shift-launch mode. The shift-launch sweep separates a correct launch shift from a missing, doubled or wrongly enabled one. The functional-launch sweep exposes a launch pulse taken with `scan_en` still high, because f(f(v1)) differs from any shifted word for most vectors. Back-to-back pairs in both mode orders, an ignored start during unload, a reset in mid-pattern, and the lengths 1 and 256 check the cycle counts and the overlap rules.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT_IN,
    ST_LAUNCH,
    ST_CAPTURE,
    ST_SHIFT_OUT,
    ST_DONE
  } lc_state_e;

  typedef enum logic {
    LM_SHIFT = 1'b0,
    LM_FUNC  = 1'b1
  } lc_mode_e;

  // One chain-side cycle as decided by the sequencer
  typedef struct packed {
    logic ce;      // enable every chain flop
    logic si;      // serial data into the chain
    logic smp;     // chain output is a response bit
    logic launch;  // this enabled cycle is the launch
    logic los;     // pattern uses shift-launch
  } lc_slot_t;
endpackage

// File: rtl/lc_delay.sv
module lc_delay #(
  parameter int W      = 1,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_wire
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] r [STAGES];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) r[i] <= '0;
        end else begin
          r[0] <= d;
          for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
        end
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lc_fsm.sv
module lc_fsm
  import lc_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int SE_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             scan_in,
  output logic             si_take,
  output logic             busy,
  output logic             done,
  output logic             se_req,
  output lc_slot_t         slot
);
  localparam int DW = (SE_STAGES < 1) ? 1 : $clog2(SE_STAGES + 1);

  lc_state_e        state;
  lc_mode_e         mode_q, pend_mode;
  logic [LEN_W-1:0] len_q, cnt;
  logic [DW-1:0]    drain;
  logic             pend;
  logic             can_queue;

  assign can_queue = start && !pend &&
                     (state == ST_SHIFT_IN || state == ST_LAUNCH || state == ST_CAPTURE);

  always_comb begin
    si_take = (state == ST_SHIFT_IN) ||
              (state == ST_SHIFT_OUT && pend) ||
              (state == ST_LAUNCH && mode_q == LM_SHIFT);
    se_req  = (state == ST_SHIFT_IN) || (state == ST_SHIFT_OUT) ||
              (state == ST_LAUNCH && mode_q == LM_SHIFT);
    slot.ce     = (state == ST_SHIFT_IN) || (state == ST_LAUNCH) ||
                  (state == ST_CAPTURE)  || (state == ST_SHIFT_OUT);
    slot.si     = si_take & scan_in;
    slot.smp    = (state == ST_SHIFT_OUT);
    slot.launch = (state == ST_LAUNCH);
    slot.los    = (mode_q == LM_SHIFT);
    busy        = (state != ST_IDLE);
    done        = (state == ST_DONE) && (drain == DW'(SE_STAGES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_q    <= LM_SHIFT;
      pend_mode <= LM_SHIFT;
      len_q     <= '0;
      cnt       <= '0;
      drain     <= '0;
      pend      <= 1'b0;
    end else begin
      if (can_queue) begin
        pend      <= 1'b1;
        pend_mode <= lc_mode_e'(mode_in);
      end
      case (state)
        ST_IDLE: if (start) begin
          len_q  <= len_in;
          mode_q <= lc_mode_e'(mode_in);
          cnt    <= '0;
          pend   <= 1'b0;
          state  <= ST_SHIFT_IN;
        end
        ST_SHIFT_IN: begin
          if (cnt == len_q) state <= ST_LAUNCH;
          else              cnt   <= cnt + 1'b1;
        end
        ST_LAUNCH:  state <= ST_CAPTURE;
        ST_CAPTURE: begin
          cnt   <= '0;
          state <= ST_SHIFT_OUT;
        end
        ST_SHIFT_OUT: begin
          if (cnt != len_q) begin
            cnt <= cnt + 1'b1;
          end else if (pend) begin
            mode_q <= pend_mode;
            pend   <= 1'b0;
            state  <= ST_LAUNCH;
          end else begin
            drain <= '0;
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (drain == DW'(SE_STAGES)) state <= ST_IDLE;
          else                         drain <= drain + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= len_q);
  // R3
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) si_take |-> busy);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R10
  no_late_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT_OUT && !pend) |=> (state != ST_LAUNCH));
endmodule

// File: rtl/atspeed_launch_ctrl.sv
module atspeed_launch_ctrl
  import lc_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int SE_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             scan_in,
  output logic             si_take,
  output logic             scan_out,
  output logic             so_valid,
  output logic             chain_si,
  input  logic             chain_so,
  output logic             chain_ce,
  output logic             scan_en,
  output logic             busy,
  output logic             done
);
  localparam int SW = $bits(lc_slot_t);

  lc_slot_t slot_req, slot_chn;
  logic     se_req;

  lc_fsm #(.LEN_W(LEN_W), .SE_STAGES(SE_STAGES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode), .len_in(len_m1),
    .scan_in(scan_in), .si_take(si_take), .busy(busy), .done(done),
    .se_req(se_req), .slot(slot_req)
  );

  // scan-enable distribution pipeline
  lc_delay #(.W(1), .STAGES(SE_STAGES)) u_se_pipe (
    .clk(clk), .rst_n(rst_n), .d(se_req), .q(scan_en)
  );

  // matched alignment for enable, data and sampling
  lc_delay #(.W(SW), .STAGES(SE_STAGES)) u_align (
    .clk(clk), .rst_n(rst_n), .d(slot_req), .q(slot_chn)
  );

  assign chain_ce = slot_chn.ce;
  assign chain_si = slot_chn.si;
  assign so_valid = slot_chn.smp;
  assign scan_out = slot_chn.smp & chain_so;

  // R4
  los_launch_se_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_chn.launch && slot_chn.los) |-> (scan_en && chain_ce));
  // R4
  capture_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_chn.launch |=> (chain_ce && !scan_en));
  // R5
  loc_launch_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_chn.launch && !slot_chn.los) |-> (chain_ce && !scan_en));
  // R6
  unload_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid |-> (scan_en && chain_ce));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scan_en && !chain_ce && !so_valid));
endmodule

// File: tb/atspeed_launch_ctrl_tb.sv
module atspeed_launch_ctrl_tb;
  localparam int P = 2;
  localparam int L = 6;

  logic clk = 1'b0;
  logic rst_n, start, mode, scan_in;
  logic [7:0] len_m1;
  logic si_take, scan_out, so_valid, chain_si, chain_so, chain_ce, scan_en, busy, done;
  logic [L-1:0] q;

  int nchk = 0, nerr = 0, cyc = 0;
  int ptr, optr, busy_cyc, dones;
  logic src_bits [1024];
  logic out_bits [1024];

  always #5 clk = ~clk;

  atspeed_launch_ctrl #(.LEN_W(8), .SE_STAGES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len_m1(len_m1),
    .scan_in(scan_in), .si_take(si_take), .scan_out(scan_out), .so_valid(so_valid),
    .chain_si(chain_si), .chain_so(chain_so), .chain_ce(chain_ce), .scan_en(scan_en),
    .busy(busy), .done(done)
  );

  function automatic logic [L-1:0] fn(input logic [L-1:0] x);
    return {x[4:0], x[5]} ^ {x[2] & x[3], 4'b0, x[5] ^ x[1]};
  endfunction

  // scan chain of multiplexed flops around fn
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (chain_ce) q <= scan_en ? {q[L-2:0], chain_si} : fn(q);
  end
  assign chain_so = q[L-1];

  // tester side: feed bits and collect response
  always @(negedge clk) begin
    if (si_take) begin scan_in = src_bits[ptr]; ptr++; end
    if (so_valid) begin out_bits[optr] = scan_out; optr++; end
    if (busy) busy_cyc++;
    if (done) dones++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nerr++;
      $display("FAIL watchdog: got %0d cycles exp < 190000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic clear();
    ptr = 0; optr = 0; busy_cyc = 0; dones = 0;
  endtask

  task automatic pulse_start(input logic m, input int l);
    @(negedge clk); start = 1'b1; mode = m; len_m1 = 8'(l);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_vec(input int base, input int v);
    for (int k = 0; k < L; k++) src_bits[base + k] = v[L-1-k];
  endtask

  function automatic int word_at(input int base);
    int w = 0;
    for (int k = 0; k < L; k++) w = (w << 1) | int'(out_bits[base + k]);
    return w;
  endfunction

  function automatic int exp_resp(input logic m, input int v, input int b);
    logic [L-1:0] v2;
    v2 = m ? fn(L'(v)) : L'((v << 1) | b);
    return int'(fn(v2));
  endfunction

  task automatic run_pair(input logic m, input int v, input int b);
    clear();
    load_vec(0, v);
    src_bits[L] = 1'(b);
    pulse_start(m, L - 1);
    wait_idle();
    if (m == 1'b0) check("R4 bits taken", ptr, L + 1);
    else           check("R5 bits taken", ptr, L);
    check("R6 bits unloaded", optr, L);
    check("R8 busy cycles", busy_cyc, 2 * L + 3 + P);
    check("R7 response", word_at(0), exp_resp(m, v, b));
  endtask

  task automatic run_b2b(input logic ma, input int va, input logic mb, input int vb);
    int base;
    clear();
    load_vec(0, va);
    base = L;
    if (ma == 1'b0) begin src_bits[L] = 1'b1; base = L + 1; end
    load_vec(base, vb);
    src_bits[base + L] = 1'b0;
    pulse_start(ma, L - 1);
    pulse_start(mb, 3);  // length field ignored for a queued pattern
    wait_idle();
    check("R9 busy cycles", busy_cyc, 3 * L + 5 + P);
    check("R9 bits taken", ptr, base + L + (mb == 1'b0 ? 1 : 0));
    check("R9 bits unloaded", optr, 2 * L);
    check("R9 first response", word_at(0), exp_resp(ma, va, 1));
    check("R9 second response", word_at(L), exp_resp(mb, vb, 0));
    check("R9 single done", dones, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; len_m1 = '0;
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 busy", int'(busy), 0);
    check("R2 scan_en", int'(scan_en), 0);
    check("R2 chain_ce", int'(chain_ce), 0);
    check("R2 done", int'(done), 0);
    check("R2 si_take/so_valid", int'(si_take | so_valid), 0);

    // R7 R4 sweep: every vector and launch bit in shift-launch mode
    for (int v = 0; v < 64; v++)
      for (int b = 0; b < 2; b++) run_pair(1'b0, v, b);
    // R7 R5 sweep: every vector in functional-launch mode
    for (int v = 0; v < 64; v++) run_pair(1'b1, v, 0);

    // R9 back-to-back in both mode orders
    run_b2b(1'b0, 6'h2d, 1'b1, 6'h13);
    run_b2b(1'b1, 6'h3a, 1'b0, 6'h05);

    // R10 start during unload is ignored
    clear();
    load_vec(0, 6'h1b);
    pulse_start(1'b1, L - 1);
    repeat (L + 3) @(negedge clk);
    start = 1'b1; mode = 1'b0;
    @(negedge clk); start = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    check("R10 busy cycles", busy_cyc, 2 * L + 3 + P);
    check("R10 bits taken", ptr, L);
    check("R10 response", word_at(0), exp_resp(1'b1, 6'h1b, 0));
    check("R10 idle after", int'(busy), 0);

    // R1 R3 R8 shortest chain length
    clear();
    src_bits[0] = 1'b1;
    pulse_start(1'b1, 0);
    wait_idle();
    check("R8 busy cycles len 1", busy_cyc, 5 + P);
    check("R3 bits taken len 1", ptr, 1);
    check("R6 bits unloaded len 1", optr, 1);
    check("R8 done pulses len 1", dones, 1);

    // R1 R3 R8 longest chain length
    clear();
    for (int k = 0; k < 300; k++) src_bits[k] = 1'(k % 3);
    pulse_start(1'b0, 255);
    wait_idle();
    check("R8 busy cycles len 256", busy_cyc, 515 + P);
    check("R3 bits taken len 256", ptr, 257);
    check("R6 bits unloaded len 256", optr, 256);

    // R2 reset in mid-pattern
    clear();
    pulse_start(1'b0, L - 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 busy after mid reset", int'(busy), 0);
    check("R2 scan_en after mid reset", int'(scan_en), 0);
    check("R2 chain_ce after mid reset", int'(chain_ce), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays idle without start", int'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule